// File: doc/BRIEF.md
# Signed Adder-Subtractor

This block adds or subtracts two signed two's-complement operands of a configurable width, chosen by a single mode bit. It has no clock and holds no state. Every output is a pure function of the present inputs. Typical uses are an ALU slice, an address offset path, or a compare-by-subtract stage.

A mode bit of 0 adds the operands. A mode bit of 1 subtracts the second operand from the first: each bit of that operand is inverted and a carry of one is fed into the lowest stage. The sum is formed by a chain of one-bit full adders.

Three outputs are provided:
- the wrapped result;
- the raw carry leaving the top stage;
- a flag that reports when the true signed answer does not fit in the width.

The overflow flag never depends on the raw carry alone.

Top module: `addsub_unit`

## Requirements
- R1: With `subMode` = 0, `result` equals (`aIn` + `bIn`) modulo 2^N.
- R2: With `subMode` = 1, `result` equals (`aIn` − `bIn`) modulo 2^N, formed as `aIn` + inverted `bIn` + 1.
- R3: `carryOut` is bit N of the unsigned (N+1)-bit sum `aIn` + B' + `subMode`, where B' is `bIn` when adding and its bitwise inverse when subtracting.
- R4: `overflow` is 1 exactly when the mathematically exact signed sum or difference lies outside the range −2^(N−1) to 2^(N−1)−1; when the two addends entering the chain differ in sign, it is 0.
- R5: `overflow` agrees with the XOR of the carry into and out of the top stage, and it can differ from `carryOut`. For N=4: 0111+0111 gives 1110, carry 0, overflow 1. 1010+1001 gives 0011, carry 1, overflow 1. 1111+1111 gives 1110, carry 1, overflow 0.
- R6: For the most negative operand at N=4: 1000−1000 gives 0000, carry 1, overflow 0. 1000−0001 gives 0111, carry 1, overflow 1. 0000−0000 gives 0000 with carry 1.
- R7: All outputs are combinational. They settle from the current inputs without any clock edge, and the default width N is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aIn | input | N | First operand, two's complement |
| bIn | input | N | Second operand, two's complement |
| subMode | input | 1 | 0 = add, 1 = subtract |
| result | output | N | Wrapped sum or difference |
| carryOut | output | 1 | Carry leaving the most significant stage |
| overflow | output | 1 | Signed result out of range |

## Verification
The in-design checks assume that inputs hold only known 0/1 values while the combinational network is evaluated. They also assume the carry chain has settled before the checks compare its end carries against the sign rule.

The bench drives only fully defined operand pairs and mode values. It changes them away from the clock edge and waits before sampling, so every check sees a settled network.

A 4-bit instance is driven in two ways:
- a short table of hand-worked corner vectors;
- every operand pair in both modes, compared against an integer reference model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;

  typedef struct packed {
    logic invertB;
    logic injectCarry;
  } addsub_strobe_t;

endpackage

// File: rtl/addsub_bit.sv
module addsub_bit (
  input  logic xBit,
  input  logic yBit,
  input  logic cIn,
  output logic sBit,
  output logic cOut
);
  always_comb begin
    sBit = xBit ^ yBit ^ cIn;
    cOut = (xBit & yBit) | (xBit & cIn) | (yBit & cIn);
  end
endmodule

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic           subMode,
  output addsub_strobe_t strobes
);
  addsub_op_e opSel;

  always_comb begin
    opSel = addsub_op_e'(subMode);
    strobes.invertB     = (opSel == OP_SUB);
    strobes.injectCarry = (opSel == OP_SUB);
  end

  always_comb begin
    if (!$isunknown(subMode)) begin
      AST_SUB_STROBES: assert (strobes.invertB == strobes.injectCarry && strobes.invertB == subMode); // R2
    end
  end
endmodule

// File: rtl/addsub_dp.sv
module addsub_dp
  import addsub_pkg::*;
#(
  parameter int N = 8,
  parameter bit OVF_BY_CARRIES = 1'b1
) (
  input  logic [N-1:0]   aIn,
  input  logic [N-1:0]   bIn,
  input  addsub_strobe_t strobes,
  output logic [N-1:0]   result,
  output logic           carryOut,
  output logic           overflow
);
  localparam int MSB = N - 1;

  logic [N-1:0] bCond;
  logic [N:0]   carry;
  logic         ovfSign;
  logic         ovfCarry;

  always_comb begin
    bCond    = bIn ^ {N{strobes.invertB}};
    carry[0] = strobes.injectCarry;
  end

  for (genvar i = 0; i < N; i++) begin : g_stage
    addsub_bit bit_i (
      .xBit(aIn[i]),
      .yBit(bCond[i]),
      .cIn (carry[i]),
      .sBit(result[i]),
      .cOut(carry[i+1])
    );
  end

  always_comb begin
    ovfSign  = (aIn[MSB] == bCond[MSB]) && (result[MSB] != aIn[MSB]);
    ovfCarry = carry[N] ^ carry[MSB];
    carryOut = carry[N];
  end

  if (OVF_BY_CARRIES) begin : g_ovf_carry
    assign overflow = ovfCarry;
  end else begin : g_ovf_sign
    assign overflow = ovfSign;
  end

  always_comb begin
    if (!$isunknown({aIn, bIn, strobes})) begin
      AST_OVF_METHODS: assert (ovfSign == ovfCarry); // R5
      AST_NO_MIXED_OVF: assert (!(aIn[MSB] != bCond[MSB]) || !overflow); // R4
      AST_CHAIN_SUM: assert ({carryOut, result} == ({1'b0, aIn} + {1'b0, bCond} + {{N{1'b0}}, strobes.injectCarry})); // R3
    end
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] aIn,
  input  logic [N-1:0] bIn,
  input  logic         subMode,
  output logic [N-1:0] result,
  output logic         carryOut,
  output logic         overflow
);
  addsub_strobe_t strobes;

  addsub_ctrl ctrl_i (
    .subMode(subMode),
    .strobes(strobes)
  );

  addsub_dp #(.N(N), .OVF_BY_CARRIES(1'b1)) dp_i (
    .aIn     (aIn),
    .bIn     (bIn),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut),
    .overflow(overflow)
  );

  always_comb begin
    if (!$isunknown({aIn, bIn, subMode}) && (aIn[N-1] != bIn[N-1]) && !subMode) begin
      AST_ADD_MIXED_SIGN: assert (!overflow); // R4
    end
  end
endmodule

// File: tb/addsub_unit_tb_top.sv
module addsub_unit_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] aIn, bIn, result;
  logic subMode, carryOut, overflow;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  addsub_unit #(.N(W)) dut_i (
    .aIn(aIn), .bIn(bIn), .subMode(subMode),
    .result(result), .carryOut(carryOut), .overflow(overflow)
  );

  // fields: sub | a | b | result | carry | overflow
  localparam logic [14:0] VEC [0:7] = '{
    {1'b0, 4'b0111, 4'b0111, 4'b1110, 1'b0, 1'b1},
    {1'b0, 4'b1010, 4'b1001, 4'b0011, 1'b1, 1'b1},
    {1'b0, 4'b1111, 4'b1111, 4'b1110, 1'b1, 1'b0},
    {1'b1, 4'b1000, 4'b1000, 4'b0000, 1'b1, 1'b0},
    {1'b1, 4'b1000, 4'b0001, 4'b0111, 1'b1, 1'b1},
    {1'b1, 4'b0011, 4'b0101, 4'b1110, 1'b0, 1'b0},
    {1'b1, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0},
    {1'b1, 4'b0111, 4'b1000, 4'b1111, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0h b=%0h sub=%0b actual=%0h expected=%0h", req, aIn, bIn, subMode, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    subMode = s; aIn = a; bIn = b;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    aIn = '0; bIn = '0; subMode = 1'b0;
    #1;
    // R7: settles with no clock edge seen
    check("R7 idle result", int'(result), 0);
    check("R7 idle carry", int'(carryOut), 0);
    check("R7 idle overflow", int'(overflow), 0);

    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][14], VEC[i][13:10], VEC[i][9:6]);
      check("R5/R6 table result", int'(result), int'(VEC[i][5:2]));
      check("R5/R6 table carry", int'(carryOut), int'(VEC[i][1]));
      check("R5/R6 table overflow", int'(overflow), int'(VEC[i][0]));
    end

    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int sa, sb, exact, expRes, expC, expV, ub;
          apply(s[0], a[3:0], b[3:0]);
          sa = (a >= 8) ? a - 16 : a;
          sb = (b >= 8) ? b - 16 : b;
          exact = (s == 1) ? sa - sb : sa + sb;
          expRes = exact & 15;
          ub = (s == 1) ? (15 - b) : b;
          expC = ((a + ub + s) >= 16) ? 1 : 0;
          expV = (exact < -8 || exact > 7) ? 1 : 0;
          check((s == 1) ? "R2 diff" : "R1 sum", int'(result), expRes);
          check("R3 carry", int'(carryOut), expC);
          check("R4 overflow", int'(overflow), expV);
        end
      end
    end

    // R7: input change between clock edges reflected immediately
    @(posedge clk); #1;
    subMode = 1'b0; aIn = 4'd3; bIn = 4'd2;
    #0.5;
    check("R7 mid-cycle", int'(result), 5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule